// File: doc/BRIEF.md
# Per-Thread Pause Counter

This block makes one hardware thread stall for a number of cycles chosen by software. Software stores a cycle count into a pause register through a write strobe and a 64-bit data word. The block drops the three low bits of that word and loads the rest into a coarse down-counter. That counter steps once for every eight clock cycles, counted by a small prescaler. While the count runs, the `blocked` output stays high, and the issue logic of the thread holds off for as long as it is set.

A count below eight still stalls the thread for exactly one cycle. When a pause runs out normally, `blocked` falls and `done` pulses for one cycle. A disrupting trap or interrupt ends a pause at once and does not raise `done`. A new write during a pause starts the pause again from the new value. Each thread of a core has its own instance.

Top module: `pause_unit`

## Requirements
- R1: After synchronous reset, `blocked` and `done` are both 0, and they stay 0 until a write arrives.
- R2: A write of value V with V >= 8 and no trap in the same cycle sets `blocked` high from the next cycle, for exactly 8*(V>>3) cycles. The three low bits of V have no effect on the length.
- R3: A write of any value from 0 to 7 sets `blocked` high for exactly one cycle.
- R4: On the clock edge where a pause runs out normally, `blocked` goes low and `done` is high for exactly that one cycle.
- R5: A trap sampled while `blocked` is high makes `blocked` low in the next cycle, and `done` stays 0.
- R6: A trap sampled while idle has no effect: `blocked` and `done` stay 0.
- R7: A write while `blocked` is high restarts the pause. It blocks for the length that R2 or R3 gives for the new value, counted from the new write. The expiry of the old pause raises no `done`.
- R8: A write and a trap in the same cycle start no pause. The trap wins, and `blocked` is low in the next cycle.
- R9: `done` and `blocked` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the pause register |
| wr_data | input | 64 | Pause length in cycles |
| trap_in | input | 1 | Disrupting trap or interrupt |
| blocked | output | 1 | Thread issue is held off |
| done | output | 1 | One-cycle pulse when a pause runs out normally |

## Verification
The bench writes values that are exact multiples of eight and values with nonzero low bits. Comparing the two shows whether the low bits are dropped. Writes of 0 and 5 show whether the below-eight case is clamped to one cycle rather than zero. Traps are applied in the middle of a long pause, while idle, and in the same cycle as a write. These show the early abort, the ignored idle trap, and the priority between trap and write. A reload in the middle of a pause and a huge value ended by a trap show whether the prescaler restarts on a write and whether the wide counter loads correctly.

// File: rtl/pause_pkg.sv
package pause_pkg;
  typedef enum logic {
    PS_IDLE = 1'b0,
    PS_HOLD = 1'b1
  } pause_state_e;
endpackage

// File: rtl/pause_prescaler.sv
module pause_prescaler #(
  parameter int GRAN_LOG2 = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic tick
);
  logic [GRAN_LOG2-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst || clear) div_q <= '0;
    else if (run)     div_q <= div_q + 1'b1;
  end

  assign tick = run && (&div_q);

  p_clear_zero_r7: assert property (@(posedge clk) disable iff (rst)
    clear |=> (div_q == '0));
endmodule

// File: rtl/pause_counter.sv
module pause_counter #(
  parameter int CNT_W = 61
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             is_zero,
  output logic             is_one
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - 1'b1;
  end

  assign is_zero = (cnt_q == '0);
  assign is_one  = (cnt_q == CNT_W'(1));

  p_no_underflow_r2: assert property (@(posedge clk) disable iff (rst)
    dec |-> !is_zero);
  p_load_value_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/pause_unit.sv
module pause_unit
  import pause_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int GRAN_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              trap_in,
  output logic              blocked,
  output logic              done
);
  localparam int CNT_W = DATA_W - GRAN_LOG2;

  pause_state_e state_q, state_d;
  logic done_q;
  logic tick, cnt_zero, cnt_one;
  logic load, finish, dec, running;
  logic [CNT_W-1:0] load_val;
  logic unused_low;

  assign load_val   = wr_data[DATA_W-1:GRAN_LOG2];
  assign unused_low = ^wr_data[GRAN_LOG2-1:0];

  assign running = (state_q == PS_HOLD) && !trap_in && !wr_en;
  assign load    = wr_en && !trap_in;
  assign finish  = running && (cnt_zero || (tick && cnt_one));
  assign dec     = running && tick && !cnt_zero && !cnt_one;

  pause_prescaler #(.GRAN_LOG2(GRAN_LOG2)) u_presc (
    .clk   (clk),
    .rst   (rst),
    .clear (wr_en || (state_q == PS_IDLE)),
    .run   (state_q == PS_HOLD),
    .tick  (tick)
  );

  pause_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .dec      (dec),
    .is_zero  (cnt_zero),
    .is_one   (cnt_one)
  );

  always_comb begin
    state_d = state_q;
    if (trap_in)     state_d = PS_IDLE;
    else if (wr_en)  state_d = PS_HOLD;
    else if (finish) state_d = PS_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PS_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
    end
  end

  assign blocked = (state_q == PS_HOLD);
  assign done    = done_q;

  p_trap_unblocks_r5: assert property (@(posedge clk) disable iff (rst)
    trap_in |=> !blocked);
  p_trap_no_done_r5: assert property (@(posedge clk) disable iff (rst)
    trap_in |=> !done);
  p_write_blocks_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !trap_in) |=> blocked);
  p_write_trap_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && trap_in) |=> !blocked);
  p_done_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> $fell(blocked));
  p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    !(done && blocked));
  p_idle_stays_r6: assert property (@(posedge clk) disable iff (rst)
    (!blocked && !wr_en) |=> !blocked);
endmodule

// File: tb/tb_pause_unit.sv
module tb_pause_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic trap_in = 1'b0;
  logic blocked, done;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string cur_req = "R1";

  logic m_blk = 1'b0;
  logic m_done = 1'b0;
  logic [63:0] m_rem = '0;

  always #10 clk = ~clk;

  pause_unit dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .trap_in(trap_in), .blocked(blocked), .done(done)
  );

  // behavioural reference: remaining cycles of the current pause
  always @(posedge clk) begin
    if (rst) begin
      m_blk <= 1'b0; m_done <= 1'b0; m_rem <= '0;
    end else if (trap_in) begin
      m_blk <= 1'b0; m_done <= 1'b0;
    end else if (wr_en) begin
      m_blk <= 1'b1; m_done <= 1'b0;
      m_rem <= ((wr_data >> 3) == 0) ? 64'd1 : ((wr_data >> 3) * 64'd8);
    end else if (m_blk) begin
      if (m_rem == 64'd1) begin
        m_blk <= 1'b0; m_done <= 1'b1;
      end else begin
        m_done <= 1'b0;
      end
      m_rem <= m_rem - 64'd1;
    end else begin
      m_done <= 1'b0;
    end
  end

  task automatic check(input string req, input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      check(cur_req, blocked, m_blk, "blocked");
      check(cur_req, done, m_done, "done");
      check("R9", done && blocked, 1'b0, "done with blocked");
    end
    if (cycles > 20000) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write(input logic [63:0] v, input logic with_trap);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v; trap_in = with_trap;
    @(negedge clk);
    wr_en = 1'b0; trap_in = 1'b0;
  endtask

  task automatic trap_pulse;
    @(negedge clk);
    trap_in = 1'b1;
    @(negedge clk);
    trap_in = 1'b0;
  endtask

  // counts blocked cycles after a write; runs alongside the per-cycle compare
  task automatic measure(input logic [63:0] v, input int expect_len, input string req);
    int len = 0;
    write(v, 1'b0);
    while (blocked === 1'b1 && len < 2000) begin
      len++;
      @(negedge clk);
    end
    total++;
    if (len != expect_len) begin
      bad++;
      $display("FAIL %s pause length: actual=%0d expected=%0d", req, len, expect_len);
    end
    check(req, done, 1'b1, "done at expiry");
  endtask

  initial begin
    idle(3);
    @(negedge clk) rst = 1'b0;
    check("R1", blocked, 1'b0, "reset blocked");
    check("R1", done, 1'b0, "reset done");
    idle(4);

    cur_req = "R2"; measure(64'd8, 8, "R2");   idle(3);
    cur_req = "R2"; measure(64'd37, 32, "R2"); idle(3);
    cur_req = "R2"; measure(64'd40, 40, "R2"); idle(3);
    cur_req = "R3"; measure(64'd5, 1, "R3");   idle(3);
    cur_req = "R3"; measure(64'd0, 1, "R3");   idle(3);
    cur_req = "R4"; measure(64'd16, 16, "R4"); idle(3);

    cur_req = "R5";
    write(64'd200, 1'b0); idle(30); trap_pulse;
    check("R5", blocked, 1'b0, "after trap");
    check("R5", done, 1'b0, "no done on trap");
    idle(5);
    write(64'h8000_0000_0000_0010, 1'b0); idle(50); trap_pulse;
    check("R5", blocked, 1'b0, "huge pause aborted");
    idle(5);

    cur_req = "R6";
    trap_pulse; idle(1);
    check("R6", blocked, 1'b0, "idle trap");
    check("R6", done, 1'b0, "idle trap done");
    idle(3);

    cur_req = "R7";
    write(64'd24, 1'b0); idle(10);
    measure(64'd16, 16, "R7");
    idle(3);
    write(64'd64, 1'b0); idle(5);
    measure(64'd3, 1, "R7");
    idle(3);

    cur_req = "R8";
    write(64'd48, 1'b1);
    check("R8", blocked, 1'b0, "write with trap");
    idle(3);
    write(64'd48, 1'b0); idle(4); write(64'd48, 1'b1);
    check("R8", blocked, 1'b0, "write with trap mid pause");
    idle(5);

    cur_req = "R4";
    write(64'd7, 1'b0); write(64'd9, 1'b0); idle(12);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule